// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block turns a 16-bit offset into a 20-bit physical address using real-mode segmentation. It holds four 16-bit segment bases: code, data, stack and extra. Each request carries an offset and an access kind. From the kind, the block picks the segment base. It then shifts the base left by four bits and adds the offset. The result is registered, so the address comes out one clock after the request.

Any carry out of the top bit is dropped, so every address stays inside a 1 MB space. Many segment:offset pairs give the same physical address. A flag marks results that land in the read-only upper region, from C0000 up to FFFFF. A write port loads the segment bases. A write only affects requests issued after the cycle in which it occurs.

Top module: `seg_addr_gen`

## Requirements
- R1: While reset is low, addr_valid, addr_out, addr_rom and addr_seg_sel are all 0. All four segment bases also reset to 0000.
- R2: The cycle after a request with req_valid high, addr_valid is 1. In that cycle, addr_out equals segment*16 + offset, taken modulo 2^20. Different pairs can give the same result: 08F1:0010 gives 08F20, and both 08F1:0000 and 08F0:0010 give 08F10.
- R3: A carry out of address bit 19 is dropped. For example, FFFF:0010 gives 00000 and FFFF:FFFF gives 0FFEF.
- R4: req_kind 2'b00 (instruction fetch) uses the code base. addr_seg_sel then reports 0.
- R5: req_kind 2'b01 (stack access) uses the stack base. addr_seg_sel then reports 2.
- R6: req_kind 2'b10 or 2'b11 (data access) uses the data base, and addr_seg_sel reports 1. If req_es_ovr is 1, it uses the extra base instead, and addr_seg_sel reports 3.
- R7: req_es_ovr has no effect on fetch or stack requests.
- R8: When seg_wr_en is 1, seg_wr_data is written to the base chosen by seg_wr_sel (0 code, 1 data, 2 stack, 3 extra). A request in the same cycle as the write still uses the old value. Requests from the next cycle onward use the new value.
- R9: With addr_valid high, addr_rom is 1 exactly when addr_out is C0000 or above.
- R10: The cycle after a cycle with no request, addr_valid is 0. addr_out, addr_rom and addr_seg_sel keep their previous values, even if a segment write happened in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seg_wr_en | input | 1 | Segment base write strobe |
| seg_wr_sel | input | 2 | Selects which base to write: 0 code, 1 data, 2 stack, 3 extra |
| seg_wr_data | input | 16 | New segment base value |
| req_valid | input | 1 | Request strobe |
| req_kind | input | 2 | Access kind: 00 fetch, 01 stack, 1x data |
| req_es_ovr | input | 1 | Makes a data access use the extra base |
| req_offset | input | 16 | Offset within the segment |
| addr_valid | output | 1 | A result is present this cycle |
| addr_out | output | 20 | Physical address |
| addr_rom | output | 1 | Result lies in the read-only region |
| addr_seg_sel | output | 2 | Base that was used, same encoding as seg_wr_sel |

## Verification
The hardest case to reach from the ports is a base write in the same cycle as a request that reads that base. The stimulus drives both on the same clock edge. It expects the old base in the address that appears one cycle later, and the new base in the address after that. The wrap-around case is reached by loading the stack base with FFFF and using offsets that push the sum past bit 19. The read-only boundary is tested with addresses BFFFF and C0000, both reached through the data base.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;

  localparam int SEG_W    = 16;
  localparam int OFF_W    = 16;
  localparam int SHIFT    = 4;
  localparam int PHYS_W   = SEG_W + SHIFT;
  localparam int NUM_SEG  = 4;
  localparam int SEL_W    = $clog2(NUM_SEG);
  localparam logic [PHYS_W-1:0] ROM_BASE = 20'hC0000;

  typedef enum logic [1:0] {
    KIND_FETCH    = 2'b00,
    KIND_STACK    = 2'b01,
    KIND_DATA     = 2'b10,
    KIND_DATA_ALT = 2'b11
  } acc_kind_e;

  typedef enum logic [SEL_W-1:0] {
    SEG_CODE  = 2'd0,
    SEG_DATA  = 2'd1,
    SEG_STACK = 2'd2,
    SEG_EXTRA = 2'd3
  } seg_id_e;

  // Base selection rule: the override only matters for data accesses
  function automatic seg_id_e pick_seg(input acc_kind_e kind, input logic es_ovr);
    seg_id_e id;
    case (kind)
      KIND_FETCH: id = SEG_CODE;
      KIND_STACK: id = SEG_STACK;
      default:    id = es_ovr ? SEG_EXTRA : SEG_DATA;
    endcase
    return id;
  endfunction

endpackage

// File: rtl/seg_bank.sv
module seg_bank
  import seg_addr_pkg::*;
#(
  parameter int W = SEG_W,
  parameter int N = NUM_SEG,
  localparam int SW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [SW-1:0] wr_sel,
  input  logic [W-1:0]  wr_data,
  input  logic [SW-1:0] rd_sel,
  output logic [W-1:0]  rd_data
);

  logic [W-1:0] base_q [N];

  for (genvar g = 0; g < N; g++) begin : g_base
    logic hit;
    assign hit = wr_en && (wr_sel == SW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   base_q[g] <= '0;
      else if (hit) base_q[g] <= wr_data;
    end
  end

  // Read returns the pre-write value during a write cycle
  assign rd_data = base_q[rd_sel];

endmodule

// File: rtl/seg_route.sv
module seg_route
  import seg_addr_pkg::*;
(
  input  logic [1:0]       kind,
  input  logic             es_ovr,
  output logic [SEL_W-1:0] sel
);

  seg_id_e id;

  always_comb begin
    id  = pick_seg(acc_kind_e'(kind), es_ovr);
    sel = SEL_W'(id);
  end

endmodule

// File: rtl/addr_form.sv
module addr_form
  import seg_addr_pkg::*;
#(
  parameter int SW = SEG_W,
  parameter int OW = OFF_W,
  parameter int SH = SHIFT,
  parameter logic [SW+SH-1:0] RB = ROM_BASE,
  localparam int PW = SW + SH
) (
  input  logic [SW-1:0] seg,
  input  logic [OW-1:0] off,
  output logic [PW-1:0] phys,
  output logic          rom_hit
);

  // Shift-and-add; width truncation drops the carry out of the top bit
  function automatic logic [PW-1:0] form_phys(input logic [SW-1:0] s,
                                              input logic [OW-1:0] o);
    logic [PW-1:0] base;
    base = {s, {SH{1'b0}}};
    return base + PW'(o);
  endfunction

  function automatic logic in_rom(input logic [PW-1:0] a);
    return a >= RB;
  endfunction

  always_comb begin
    phys    = form_phys(seg, off);
    rom_hit = in_rom(phys);
  end

endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
  import seg_addr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              seg_wr_en,
  input  logic [SEL_W-1:0]  seg_wr_sel,
  input  logic [SEG_W-1:0]  seg_wr_data,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic              req_es_ovr,
  input  logic [OFF_W-1:0]  req_offset,
  output logic              addr_valid,
  output logic [PHYS_W-1:0] addr_out,
  output logic              addr_rom,
  output logic [SEL_W-1:0]  addr_seg_sel
);

  // Named internal events
  logic [SEL_W-1:0]  route_sel;
  logic [SEG_W-1:0]  sel_seg_val;
  logic [PHYS_W-1:0] phys_d;
  logic              rom_d;

  seg_route u_route (
    .kind   (req_kind),
    .es_ovr (req_es_ovr),
    .sel    (route_sel)
  );

  seg_bank #(.W(SEG_W), .N(NUM_SEG)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (seg_wr_en),
    .wr_sel  (seg_wr_sel),
    .wr_data (seg_wr_data),
    .rd_sel  (route_sel),
    .rd_data (sel_seg_val)
  );

  addr_form #(.SW(SEG_W), .OW(OFF_W), .SH(SHIFT), .RB(ROM_BASE)) u_form (
    .seg     (sel_seg_val),
    .off     (req_offset),
    .phys    (phys_d),
    .rom_hit (rom_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_valid   <= 1'b0;
      addr_out     <= '0;
      addr_rom     <= 1'b0;
      addr_seg_sel <= '0;
    end else begin
      addr_valid <= req_valid;
      if (req_valid) begin
        addr_out     <= phys_d;
        addr_rom     <= rom_d;
        addr_seg_sel <= route_sel;
      end
    end
  end

endmodule

// File: rtl/seg_addr_gen_chk.sv
module seg_addr_gen_chk
  import seg_addr_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [1:0]        req_kind,
  input logic              req_es_ovr,
  input logic [OFF_W-1:0]  req_offset,
  input logic [SEG_W-1:0]  sel_seg_val,
  input logic              addr_valid,
  input logic [PHYS_W-1:0] addr_out,
  input logic              addr_rom,
  input logic [SEL_W-1:0]  addr_seg_sel
);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (!addr_valid && addr_out == '0 && !addr_rom && addr_seg_sel == '0));

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> addr_valid);

  // R2
  addr_math_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> addr_out ==
      PHYS_W'({$past(sel_seg_val), {SHIFT{1'b0}}} + PHYS_W'($past(req_offset))));

  // R4
  fetch_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == 2'b00) |=> addr_seg_sel == 2'd0);

  // R5
  stack_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == 2'b01) |=> addr_seg_sel == 2'd2);

  // R6
  data_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind[1]) |=> addr_seg_sel == ($past(req_es_ovr) ? 2'd3 : 2'd1));

  // R9
  rom_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid |-> addr_rom == (addr_out >= ROM_BASE));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!addr_valid && $stable(addr_out) && $stable(addr_seg_sel)));

endmodule

bind seg_addr_gen seg_addr_gen_chk chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_kind     (req_kind),
  .req_es_ovr   (req_es_ovr),
  .req_offset   (req_offset),
  .sel_seg_val  (sel_seg_val),
  .addr_valid   (addr_valid),
  .addr_out     (addr_out),
  .addr_rom     (addr_rom),
  .addr_seg_sel (addr_seg_sel)
);

// File: tb/seg_addr_gen_tb_top.sv
`timescale 1ns/1ps
module seg_addr_gen_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        seg_wr_en = 1'b0;
  logic [1:0]  seg_wr_sel = '0;
  logic [15:0] seg_wr_data = '0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_kind = '0;
  logic        req_es_ovr = 1'b0;
  logic [15:0] req_offset = '0;
  logic        addr_valid;
  logic [19:0] addr_out;
  logic        addr_rom;
  logic [1:0]  addr_seg_sel;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  seg_addr_gen dut_i (
    .clk(clk), .rst_n(rst_n),
    .seg_wr_en(seg_wr_en), .seg_wr_sel(seg_wr_sel), .seg_wr_data(seg_wr_data),
    .req_valid(req_valid), .req_kind(req_kind), .req_es_ovr(req_es_ovr),
    .req_offset(req_offset),
    .addr_valid(addr_valid), .addr_out(addr_out), .addr_rom(addr_rom),
    .addr_seg_sel(addr_seg_sel)
  );

  // kind, override, offset, expected address, expected base id
  // Bases: code 08F1, data 08F0, stack FFFF, extra C000
  typedef struct packed {
    logic [1:0]  kind;
    logic        ovr;
    logic [15:0] off;
    logic [19:0] exp_addr;
    logic [1:0]  exp_sel;
  } vec_t;

  localparam vec_t VECS [12] = '{
    '{2'b00, 1'b0, 16'h0010, 20'h08F20, 2'd0},  // R2 R4
    '{2'b00, 1'b0, 16'h0000, 20'h08F10, 2'd0},  // R2 alias
    '{2'b10, 1'b0, 16'h0010, 20'h08F10, 2'd1},  // R2 alias R6
    '{2'b01, 1'b0, 16'h0010, 20'h00000, 2'd2},  // R3 R5
    '{2'b01, 1'b0, 16'h000F, 20'hFFFFF, 2'd2},  // R5 R9
    '{2'b10, 1'b1, 16'h1234, 20'hC1234, 2'd3},  // R6 R9
    '{2'b00, 1'b1, 16'h0010, 20'h08F20, 2'd0},  // R7
    '{2'b01, 1'b1, 16'hFFFF, 20'h0FFEF, 2'd2},  // R7 R3
    '{2'b11, 1'b0, 16'h0000, 20'h08F00, 2'd1},  // R6
    '{2'b11, 1'b1, 16'h0005, 20'hC0005, 2'd3},  // R6
    '{2'b10, 1'b0, 16'hFFFF, 20'h18EFF, 2'd1},  // R2
    '{2'b10, 1'b1, 16'h0000, 20'hC0000, 2'd3}   // R9
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_seg(input logic [1:0] sel, input logic [15:0] val);
    seg_wr_en = 1'b1; seg_wr_sel = sel; seg_wr_data = val;
    @(negedge clk);
    seg_wr_en = 1'b0;
  endtask

  task automatic issue(input logic [1:0] kind, input logic ovr, input logic [15:0] off);
    req_valid = 1'b1; req_kind = kind; req_es_ovr = ovr; req_offset = off;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic expect_addr(input string req, input logic [19:0] a, input logic [1:0] s);
    check({req, " valid"}, 32'(addr_valid), 32'd1);
    check({req, " addr"},  32'(addr_out), 32'(a));
    check({req, " sel"},   32'(addr_seg_sel), 32'(s));
    check({req, " rom"},   32'(addr_rom), 32'(a >= 20'hC0000));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 valid", 32'(addr_valid), 32'd0);
    check("R1 addr",  32'(addr_out), 32'd0);
    check("R1 rom",   32'(addr_rom), 32'd0);
    check("R1 sel",   32'(addr_seg_sel), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    issue(2'b10, 1'b1, 16'h0000);
    expect_addr("R1 extra base zero", 20'h00000, 2'd3);
    issue(2'b01, 1'b0, 16'h0042);
    expect_addr("R1 stack base zero", 20'h00042, 2'd2);

    wr_seg(2'd0, 16'h08F1);
    wr_seg(2'd1, 16'h08F0);
    wr_seg(2'd2, 16'hFFFF);
    wr_seg(2'd3, 16'hC000);

    for (int i = 0; i < 12; i++) begin
      issue(VECS[i].kind, VECS[i].ovr, VECS[i].off);
      expect_addr($sformatf("R2 vector %0d", i), VECS[i].exp_addr, VECS[i].exp_sel);
    end

    // R8 write and request in the same cycle: old base first, new base next
    seg_wr_en = 1'b1; seg_wr_sel = 2'd0; seg_wr_data = 16'h1000;
    issue(2'b00, 1'b0, 16'h0020);
    seg_wr_en = 1'b0;
    expect_addr("R8 same cycle old", 20'h08F30, 2'd0);
    issue(2'b00, 1'b0, 16'h0020);
    expect_addr("R8 next request new", 20'h10020, 2'd0);

    // R10 idle cycle with a write: outputs hold, valid drops
    wr_seg(2'd0, 16'h2000);
    check("R10 valid low", 32'(addr_valid), 32'd0);
    check("R10 addr held", 32'(addr_out), 32'h10020);
    check("R10 sel held",  32'(addr_seg_sel), 32'd0);
    check("R10 rom held",  32'(addr_rom), 32'd0);

    // R9 boundary just below and at the read-only base
    wr_seg(2'd1, 16'hBFFF);
    issue(2'b10, 1'b0, 16'h000F);
    expect_addr("R9 below", 20'hBFFFF, 2'd1);
    issue(2'b10, 1'b0, 16'h0010);
    expect_addr("R9 at base", 20'hC0000, 2'd1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule